// File: doc/BRIEF.md
# Frame-Slot GPIO Bank

This block sits inside the endpoint of a serial audio codec link and owns a bank of general-purpose pins. It takes no part in framing or serialization: once per frame the link logic presents the parallel 20-bit control word received in the GPIO slot and pulses a frame tick. At that tick the bank reloads its pin data from the received word and captures a fresh status word. The link logic shifts that status word out in the GPIO slot of the outgoing frame, and it stays constant for the whole frame.

A direction mask, held apart from the pin data, decides which pins are driven. Driven pins follow their slot bit every frame. Undriven pins are sampled through a two-flop synchronizer and reported in the status word. Each undriven pin also keeps a sticky change flag, and any set flag raises an interrupt. Status always trails the control word by one frame. Every pin stays tri-stated after reset until the controller writes the direction mask, so it can place a level first and enable the driver afterwards.

The slot words arrive at the fixed frame rate and are taken in one clock cycle. There is no valid/ready pair and no back-pressure: `frame_tick` is the only qualifier, and the bank never stalls the link.

Top module: `gpio_slot_bank`

## Requirements
- R1: After reset `pin_oe`, `pin_out`, `tx_slot`, `irq` and both configuration registers are zero, so every pin is tri-stated.
- R2: Writing configuration select 0 sets the direction mask, where bit i = 1 makes pin i an output. `pin_oe` equals the mask in the cycle after the write, and the mask reads back on select 0.
- R3: At every `frame_tick` the pin data reloads from `rx_slot[19:4]`, with pin i taken from bit i+4. An output pin therefore changes on each new frame and is not latched once.
- R4: While a pin is an input, its received slot bit does not enable the pin, and the status word reports the pin's sampled level for that bit.
- R5: The pin data loads even while the pin is an input. When the direction bit is later set, the pin drives the most recently received level with no further frame.
- R6: At a `frame_tick`, `tx_slot[i+4]` for an input pin takes the level seen two clocks earlier through the synchronizer. `tx_slot` then holds until the next tick, whatever the pins do in between.
- R7: For an output pin, `tx_slot[i+4]` captured at a tick is the level the pin drove before that tick. A value received in frame k therefore first appears in status at frame k+1.
- R8: `tx_slot[0]` carries the interrupt state at the capture. `tx_slot[3:1]` are always zero, and the low four bits of `rx_slot` have no effect.
- R9: Any edge on a synchronized input pin sets that pin's sticky change flag. The flags read back on configuration select 1, and `irq` is the OR of all flags.
- R10: Writing ones to select 1 clears exactly those flags and leaves the others set. Level changes on pins configured as outputs never set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary; qualifies `rx_slot` |
| rx_slot | input | 20 | Received GPIO control slot word |
| tx_slot | output | 20 | Status slot word, held for the whole outgoing frame |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 direction mask, 1 change flags |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data for `cfg_sel` |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Pad output levels |
| pin_oe | output | 16 | Pad output enables, 1 = drive |
| irq | output | 1 | Interrupt request, OR of change flags |

## Verification
The bench loads a level into a pin while it is still an input, then enables it. A design that gated the data load on direction would drive zero instead of the loaded level. A design that let the slot bit leak through would show the written bit in status instead of the pad level. Status is compared frame against frame to catch a design that reports the freshly received word instead of the previous one. The pins are also moved between ticks, which catches a status word that is not held. Partial W1C clears and toggles on output pins expose flags that clear too much or latch edges from driven pins.

// File: rtl/gpio_slot_pkg.sv
package gpio_slot_pkg;
  typedef enum logic {
    SEL_DIR = 1'b0,
    SEL_CHG = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] dir,
  output logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] chg
);
  logic [NPINS-1:0] meta_q, lvl_q, prev_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        lvl_q[g]  <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= pin_in[g];
        lvl_q[g]  <= meta_q[g];
        prev_q[g] <= lvl_q[g];
      end
    end
    // an edge only counts while the pin is an input
    assign chg[g] = (lvl_q[g] ^ prev_q[g]) & ~dir[g];
  end

  assign lvl = lvl_q;
endmodule

// File: rtl/gpio_chg_flags.sv
module gpio_chg_flags #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] chg,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] flags,
  output logic             irq
);
  logic [NPINS-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (clr_we) flags_q <= (flags_q & ~clr_mask) | chg;
    else flags_q <= flags_q | chg;
  end

  assign flags = flags_q;
  assign irq   = |flags_q;

  // flags never fall without a clear write
  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (($past(flags_q) & ~flags_q) == '0));
endmodule

// File: rtl/gpio_slot_io.sv
module gpio_slot_io #(
  parameter int NPINS  = 16,
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [SLOT_W-1:0] rx_slot,
  input  logic [NPINS-1:0]  dir,
  input  logic [NPINS-1:0]  in_lvl,
  input  logic              irq,
  output logic [NPINS-1:0]  out_q,
  output logic [SLOT_W-1:0] tx_slot
);
  localparam int PIN_LSB = SLOT_W - NPINS;

  logic [NPINS-1:0]  data_q;
  logic [SLOT_W-1:0] tx_q, tx_d;
  logic              unused_rx_lsbs;

  assign unused_rx_lsbs = ^rx_slot[PIN_LSB-1:0];

  always_comb begin
    tx_d = '0;
    // driven pins report the level held before this tick
    tx_d[PIN_LSB +: NPINS] = (dir & data_q) | (~dir & in_lvl);
    tx_d[0] = irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      tx_q   <= '0;
    end else if (frame_tick) begin
      data_q <= rx_slot[SLOT_W-1:PIN_LSB];
      tx_q   <= tx_d;
    end
  end

  assign out_q   = data_q;
  assign tx_slot = tx_q;

  assert_refresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> out_q == $past(rx_slot[SLOT_W-1:PIN_LSB]));

  assert_tx_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(tx_slot));
endmodule

// File: rtl/gpio_slot_bank.sv
module gpio_slot_bank #(
  parameter int NPINS  = 16,
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [SLOT_W-1:0] rx_slot,
  output logic [SLOT_W-1:0] tx_slot,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [NPINS-1:0]  cfg_wdata,
  output logic [NPINS-1:0]  cfg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  import gpio_slot_pkg::*;

  localparam int PIN_LSB = SLOT_W - NPINS;

  logic [NPINS-1:0] dir_q, in_lvl, chg, flags;
  logic             dir_we, clr_we;

  assign dir_we = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_DIR);
  assign clr_we = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_CHG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else if (dir_we) dir_q <= cfg_wdata;
  end

  gpio_in_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir(dir_q),
    .lvl(in_lvl), .chg(chg)
  );

  gpio_chg_flags #(.NPINS(NPINS)) u_flags (
    .clk(clk), .rst_n(rst_n), .chg(chg), .clr_we(clr_we),
    .clr_mask(cfg_wdata), .flags(flags), .irq(irq)
  );

  gpio_slot_io #(.NPINS(NPINS), .SLOT_W(SLOT_W)) u_io (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .rx_slot(rx_slot),
    .dir(dir_q), .in_lvl(in_lvl), .irq(irq), .out_q(pin_out), .tx_slot(tx_slot)
  );

  assign pin_oe    = dir_q;
  assign cfg_rdata = (cfg_sel_e'(cfg_sel) == SEL_CHG) ? flags : dir_q;

  // driven pins show last frame's drive, never this frame's word
  assert_status_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> ((tx_slot[SLOT_W-1:PIN_LSB] & $past(pin_oe)) ==
                    ($past(pin_out) & $past(pin_oe))));

  assert_irq_in_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> (tx_slot[0] == $past(irq)));
endmodule

// File: tb/sim_gpio_slot_bank.sv
module sim_gpio_slot_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic [19:0] rx_slot = '0;
  logic [19:0] tx_slot;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;
  int          total = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  gpio_slot_bank u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .rx_slot(rx_slot),
    .tx_slot(tx_slot), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] pins, input logic [3:0] low);
    @(negedge clk);
    rx_slot = {pins, low};
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic cfg_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic sel, output logic [15:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] r;
    chk("R1 pin_oe", {4'h0, pin_oe}, 20'h0);
    chk("R1 pin_out", {4'h0, pin_out}, 20'h0);
    chk("R1 tx_slot", tx_slot, 20'h0);
    chk("R1 irq", {19'h0, irq}, 20'h0);
    cfg_read(1'b0, r);
    chk("R1 dir reg", {4'h0, r}, 20'h0);
  endtask

  task automatic t_preload_enable;
    logic [15:0] r;
    frame(16'hF00F, 4'h0);
    chk("R4 oe stays low", {4'h0, pin_oe}, 20'h0);
    frame(16'hF00F, 4'h0);
    chk("R4 status is pad level", tx_slot, 20'h0);
    cfg_write(1'b0, 16'hFFFF);
    chk("R2 oe follows mask", {4'h0, pin_oe}, 20'h0FFFF);
    chk("R5 preloaded level driven", {4'h0, pin_out}, 20'h0F00F);
    cfg_read(1'b0, r);
    chk("R2 mask readback", {4'h0, r}, 20'h0FFFF);
  endtask

  task automatic t_refresh_lag;
    frame(16'h1234, 4'hF);
    chk("R3 refresh 1", {4'h0, pin_out}, 20'h01234);
    chk("R7 status shows prior drive", tx_slot, {16'hF00F, 4'h0});
    frame(16'hBEEF, 4'hF);
    chk("R3 refresh 2", {4'h0, pin_out}, 20'h0BEEF);
    chk("R7 one frame lag", tx_slot, {16'h1234, 4'h0});
    chk("R8 low bits zero", {16'h0, tx_slot[3:0]}, 20'h0);
  endtask

  task automatic t_inputs;
    logic [15:0] r;
    cfg_write(1'b0, 16'h00FF);
    @(negedge clk); pin_in = 16'h5A00;
    repeat (4) @(negedge clk);
    chk("R9 irq raised", {19'h0, irq}, 20'h1);
    cfg_read(1'b1, r);
    chk("R9 flags readback", {4'h0, r}, 20'h05A00);
    frame(16'h33CC, 4'h0);
    chk("R6 mixed status", tx_slot, {16'h5AEF, 4'h1});
    chk("R4 driven bits only", {4'h0, pin_out & pin_oe}, 20'h000CC);
    pin_in = 16'hFF00;
    repeat (4) @(negedge clk);
    chk("R6 status held in frame", tx_slot, {16'h5AEF, 4'h1});
  endtask

  task automatic t_clear;
    logic [15:0] r;
    cfg_write(1'b1, 16'h0F00);
    cfg_read(1'b1, r);
    chk("R10 partial clear", {4'h0, r}, 20'h0F000);
    chk("R10 irq still set", {19'h0, irq}, 20'h1);
    pin_in = 16'hFFFF;
    repeat (4) @(negedge clk);
    cfg_read(1'b1, r);
    chk("R10 output-pin edges ignored", {4'h0, r}, 20'h0F000);
    cfg_write(1'b1, 16'hFFFF);
    chk("R9 irq drops when all clear", {19'h0, irq}, 20'h0);
    frame(16'h0000, 4'h0);
    chk("R8 irq bit clear in slot", tx_slot, {16'hFFCC, 4'h0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_preload_enable();
    t_refresh_lag();
    t_inputs();
    t_clear();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule